// File: doc/BRIEF.md
# Buffered Serializer with Input Holding Register

This block turns a parallel byte into a serial bit stream. It has two stages. The first is a holding register that captures the parallel inputs whenever its capture strobe is pulsed. The second is a shift stage that sends its most significant bit out on a single serial output. Because the holding register has its own strobe, the next byte can be captured while the current byte is still leaving the shift stage. A level-driven load control then copies the held byte into the shift stage.

An active-low clear control empties the shift stage and leaves the holding register alone. When neither control is active, a shift strobe moves the shift stage up one place and feeds a serial input into bit 0. The block runs on one system clock. Both strobes are sampled as single-cycle enables on its rising edge. Load and clear are sampled as levels on every edge, with a fixed priority. Driving load and clear low together is illegal, and an error output flags it.

Every effect is registered. A change becomes visible on the outputs one system-clock cycle after the edge that samples the inputs causing it.

Top module: `buffered_serializer`

## Requirements
- R1: On every clock with cap_stb high, the holding register takes par_in, whatever load_n, clear_n and shf_stb are doing. Without cap_stb it keeps its value, and clear_n never changes it.
- R2: On every clock with load_n low and clear_n high, the shift stage is reloaded from the holding register. No shift strobe is needed, and the reload repeats for as long as load_n stays low.
- R3: When cap_stb is high in the same clock as an active load (load_n low, clear_n high), the shift stage takes par_in directly in that clock, not the older held value.
- R4: On every clock with clear_n low and load_n high, all bits of the shift stage become 0, so ser_out is 0 on the next cycle.
- R5: On a clock with load_n and clear_n both low, ctl_err is 1 on the next cycle. Otherwise ctl_err is 0 on the next cycle. While the error lasts the shift stage holds its contents, and those contents are treated as unspecified until the next load or clear.
- R6: On a clock with shf_stb high and both load_n and clear_n high, bit n of the shift stage takes bit n-1, and bit 0 takes ser_in. ser_out always shows the top bit (bit WIDTH-1), so a loaded byte leaves most significant bit first.
- R7: A shift strobe has no effect while load_n or clear_n is low. With no strobe and no active control, the shift stage holds its value.
- R8: A clock with rst high clears the holding register, the shift stage and ctl_err. rst overrides every other input. After it, a load with no capture sends out all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| par_in | input | WIDTH | Parallel data for the holding register |
| cap_stb | input | 1 | Capture strobe for the holding register |
| load_n | input | 1 | Active-low level load of the shift stage |
| clear_n | input | 1 | Active-low clear of the shift stage |
| shf_stb | input | 1 | Shift strobe for the shift stage |
| ser_in | input | 1 | Serial data shifted into bit 0 |
| ser_out | output | 1 | Serial output, top bit of the shift stage |
| ctl_err | output | 1 | Registered flag for load and clear driven low together |

## Verification
Every one of the 256 byte values is captured, loaded and then shifted sixteen times, with the serial input carrying a value derived from that byte. The first eight output bits show the byte leaving most significant bit first. The last eight show the serial input arriving, which separates a correct shift direction from a reversed one and from a dropped serial input. Directed sequences capture a new byte midway through a shift-out, pulse capture in the same clock as a load, and hold shift strobes through load and clear. Each of these is followed by a shift-out whose pattern shows whether the held byte, the bypassed input or a cleared stage reached the output. A clear in the middle of a shift-out, the illegal load-plus-clear combination and the reset state are also checked, and each ends with an observation of both outputs.

// File: rtl/bser_pkg.sv
package bser_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_SHIFT = 3'd1,
    OP_LOAD  = 3'd2,
    OP_CLR   = 3'd3,
    OP_ERR   = 3'd4
  } op_t;
endpackage

// File: rtl/bser_hold.sv
module bser_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_stb,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '0;
    else if (cap_stb) hold_q <= par_in;
  end

  // R1: capture on strobe
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> hold_q == $past(par_in));
  // R1: no strobe keeps the held byte
  p_keep_r1: assert property (@(posedge clk) disable iff (rst)
    !cap_stb |=> $stable(hold_q));
  // R8: reset clears the held byte
  p_reset_r8: assert property (@(posedge clk)
    rst |=> hold_q == '0);
endmodule

// File: rtl/bser_ctl.sv
module bser_ctl
  import bser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_n,
  input  logic clear_n,
  input  logic shf_stb,
  output op_t  op,
  output logic err_q
);
  always_comb begin
    if (!load_n && !clear_n) op = OP_ERR;
    else if (!clear_n)       op = OP_CLR;
    else if (!load_n)        op = OP_LOAD;
    else if (shf_stb)        op = OP_SHIFT;
    else                     op = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (op == OP_ERR);
  end

  // R5: illegal control pair flagged on the next cycle
  p_err_set_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !clear_n) |=> err_q);
  // R5: flag drops once either control is released
  p_err_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (load_n || clear_n) |=> !err_q);
endmodule

// File: rtl/bser_shift.sv
module bser_shift
  import bser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  op_t              op,
  input  logic             cap_stb,
  input  logic [WIDTH-1:0] par_in,
  input  logic [WIDTH-1:0] hold_q,
  input  logic             ser_in,
  output logic [WIDTH-1:0] sh_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] load_src;
  assign load_src = cap_stb ? par_in : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      unique case (op)
        OP_CLR:   sh_q <= '0;
        OP_LOAD:  sh_q <= load_src;
        OP_SHIFT: sh_q <= {sh_q[MSB-1:0], ser_in};
        default:  sh_q <= sh_q;
      endcase
    end
  end

  // R2: level load from the holding register
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD && !cap_stb) |=> sh_q == $past(hold_q));
  // R3: same-clock capture bypasses into the shift stage
  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD && cap_stb) |=> sh_q == $past(par_in));
  // R4: clear empties the shift stage
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLR) |=> sh_q == '0);
  // R6: shift moves up and takes the serial input
  p_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (sh_q[0] == $past(ser_in)) &&
                         (sh_q[MSB:1] == $past(sh_q[MSB-1:0])));
  // R7: idle and error both hold
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE || op == OP_ERR) |=> $stable(sh_q));
endmodule

// File: rtl/buffered_serializer.sv
module buffered_serializer
  import bser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_stb,
  input  logic             load_n,
  input  logic             clear_n,
  input  logic             shf_stb,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ctl_err
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] sh_q;
  op_t              op;

  bser_hold #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst(rst), .cap_stb(cap_stb), .par_in(par_in), .hold_q(hold_q)
  );

  bser_ctl u_ctl (
    .clk(clk), .rst(rst), .load_n(load_n), .clear_n(clear_n),
    .shf_stb(shf_stb), .op(op), .err_q(ctl_err)
  );

  bser_shift #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .op(op), .cap_stb(cap_stb), .par_in(par_in),
    .hold_q(hold_q), .ser_in(ser_in), .sh_q(sh_q)
  );

  assign ser_out = sh_q[MSB];

  // R4: clear seen at the serial output
  p_clear_out_r4: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && load_n) |=> !ser_out);
  // R8: reset seen at the outputs
  p_reset_out_r8: assert property (@(posedge clk)
    rst |=> (!ser_out && !ctl_err));
endmodule

// File: tb/buffered_serializer_test.sv
`timescale 1ns/100ps
module buffered_serializer_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, cap_stb, load_n, clear_n, shf_stb, ser_in;
  logic [W-1:0] par_in;
  logic         ser_out, ctl_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_hold, m_sh;
  logic         m_err, m_valid;

  always #2.5 clk = ~clk;

  buffered_serializer #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .par_in(par_in), .cap_stb(cap_stb),
    .load_n(load_n), .clear_n(clear_n), .shf_stb(shf_stb),
    .ser_in(ser_in), .ser_out(ser_out), .ctl_err(ctl_err)
  );

  task automatic idle_in();
    cap_stb = 1'b0; load_n = 1'b1; clear_n = 1'b1; shf_stb = 1'b0; ser_in = 1'b0;
  endtask

  // one clock: update the spec model from the held inputs, then check outputs
  task automatic cyc(input string tag);
    logic [W-1:0] nh, ns;
    logic ne, nv;
    @(posedge clk);
    nh = m_hold; ns = m_sh; ne = 1'b0; nv = m_valid;
    if (rst) begin
      nh = '0; ns = '0; nv = 1'b1;
    end else begin
      if (cap_stb) nh = par_in;
      if (!load_n && !clear_n) begin ne = 1'b1; nv = 1'b0; end
      else if (!clear_n) begin ns = '0; nv = 1'b1; end
      else if (!load_n) begin ns = cap_stb ? par_in : m_hold; nv = 1'b1; end
      else if (shf_stb) ns = {m_sh[W-2:0], ser_in};
    end
    m_hold = nh; m_sh = ns; m_err = ne; m_valid = nv;
    @(negedge clk);
    checks++;
    if (ctl_err !== m_err) begin
      fails++;
      $display("FAIL %s ctl_err actual=%b expected=%b", tag, ctl_err, m_err);
    end
    if (m_valid) begin
      checks++;
      if (ser_out !== m_sh[W-1]) begin
        fails++;
        $display("FAIL %s ser_out actual=%b expected=%b", tag, ser_out, m_sh[W-1]);
      end
    end
  endtask

  task automatic capture(input logic [W-1:0] v, input string tag);
    par_in = v; cap_stb = 1'b1; cyc(tag); cap_stb = 1'b0;
  endtask

  task automatic load(input string tag);
    load_n = 1'b0; cyc(tag); load_n = 1'b1;
  endtask

  task automatic shift_n(input int n, input logic [15:0] bits, input string tag);
    for (int i = 0; i < n; i++) begin
      shf_stb = 1'b1; ser_in = bits[15-i]; cyc(tag);
    end
    shf_stb = 1'b0; ser_in = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_hold = '0; m_sh = '0; m_err = 1'b0; m_valid = 1'b0;
    par_in = 8'h5A;
    idle_in();
    rst = 1'b1;
    @(negedge clk);
    cyc("R8"); cyc("R8");
    rst = 1'b0;

    // R8: holding register was cleared: load without capture sends zeros
    load("R8");
    shift_n(8, 16'h0000, "R8");

    // R1 R2 R6: sweep every byte, shift 16 to see the serial input emerge
    for (int v = 0; v < 256; v++) begin
      capture(W'(v), "R1");
      load("R2");
      shift_n(16, {W'(v), W'(v) ^ 8'hA5}, "R6");
    end

    // R1: capture a new byte while the previous one is leaving
    capture(8'hC3, "R1");
    load("R2");
    shift_n(3, 16'hFFFF, "R6");
    capture(8'h96, "R1");
    par_in = 8'h00;
    shift_n(5, 16'h0000, "R6");
    load("R1");
    shift_n(8, 16'h0000, "R1");

    // R3: capture strobe in the same clock as the load bypasses
    capture(8'h0F, "R1");
    par_in = 8'hE1; cap_stb = 1'b1; load_n = 1'b0;
    cyc("R3");
    cap_stb = 1'b0; load_n = 1'b1;
    shift_n(8, 16'h0000, "R3");

    // R2 R7: held load ignores shift strobes and keeps reloading
    capture(8'hB4, "R1");
    load_n = 1'b0; shf_stb = 1'b1; ser_in = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R7");
    load_n = 1'b1; shf_stb = 1'b0; ser_in = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R7");
    shift_n(8, 16'h0000, "R2");

    // R4: clear during a shift-out, holding register untouched
    capture(8'hFF, "R1");
    load("R2");
    shift_n(2, 16'h0000, "R6");
    clear_n = 1'b0; shf_stb = 1'b1; ser_in = 1'b1;
    cyc("R4"); cyc("R7");
    clear_n = 1'b1; shf_stb = 1'b0; ser_in = 1'b0;
    shift_n(8, 16'h0000, "R4");
    load("R4");
    shift_n(8, 16'h0000, "R4");

    // R5: illegal pair raises the flag, then a clear restores a known state
    capture(8'h3C, "R1");
    load_n = 1'b0; clear_n = 1'b0;
    cyc("R5"); cyc("R5");
    load_n = 1'b1; clear_n = 1'b1;
    cyc("R5");
    clear_n = 1'b0; cyc("R5"); clear_n = 1'b1;
    shift_n(4, 16'h0000, "R5");
    load("R5");
    shift_n(8, 16'h0000, "R5");

    // R8: reset in the middle of activity
    capture(8'hAA, "R1");
    load("R2");
    rst = 1'b1; cap_stb = 1'b1; par_in = 8'h77; cyc("R8");
    rst = 1'b0; cap_stb = 1'b0;
    load("R8");
    shift_n(8, 16'h0000, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule